// File: doc/BRIEF.md
# Sub-Word Access Bridge for a Dword-Only Register Space

This block sits between a requester that reads and writes 1, 2 or 4 bytes at a time and a register target that only accepts whole, 32-bit aligned dwords. A read always fetches the enclosing dword. The bridge then moves the addressed lane down to bit 0 and clears the bits above the requested width. A 4-byte write is sent as one dword write. A byte or halfword write becomes a read-modify-write: the bridge fetches the dword, replaces only the addressed lane, and stores the dword back.

A request is rejected with an error response, and the target is never touched, when its size is not 1, 2 or 4 or when its address is not a multiple of its size. Only one request is handled at a time. The front side uses a valid/ready request and a one-cycle response pulse. The back side has separate read and write strobes, and each strobe is held until the target acknowledges it.

Top module: `sw_dword_bridge`

## Requirements
- R1: Every back-end access uses the request address with bits 1:0 cleared. The byte offset is request address bits 1:0.
- R2: `req_size` gives the size as a byte count. Only the values 1, 2 and 4 are legal. Any other value gives a response with `rsp_err`=1 and no back-end access.
- R3: A request whose address is not a multiple of its size (a halfword with address bit 0 set, or a dword with bits 1:0 not zero) gives a response with `rsp_err`=1 and no back-end access.
- R4: A legal read makes exactly one back-end read and no write. `rsp_rdata` is the fetched dword shifted right by offset×8 and masked to 8, 16 or 32 bits, so every bit above the requested width is zero.
- R5: A rejected read returns `rsp_rdata` of all ones. Every write response returns `rsp_rdata` of zero.
- R6: A legal 4-byte write makes exactly one back-end write carrying `req_wdata` unchanged, and no back-end read.
- R7: A legal 1- or 2-byte write makes one back-end read and then one back-end write. The write strobe rises in the cycle after the read is acknowledged. The stored dword changes only in the lane at offset×8 of the request width, and that lane takes the low bits of `req_wdata`.
- R8: After a request is accepted, `req_ready` stays low until the cycle after the response. `rsp_valid` is high for exactly one cycle for each request.
- R9: `bk_rd` and `bk_wr` are never high together. A strobe stays high until the cycle in which `bk_ack` is seen.
- R10: While reset is held and right after it, `req_ready`=1 and `rsp_valid`, `bk_rd` and `bk_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Access size as a byte count (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, right-justified |
| bk_rd | output | 1 | Back-end dword read strobe |
| bk_wr | output | 1 | Back-end dword write strobe |
| bk_addr | output | ADDR_W | Back-end dword-aligned address |
| bk_wdata | output | 32 | Back-end write dword |
| bk_rdata | input | 32 | Back-end read dword, valid with bk_ack |
| bk_ack | input | 1 | Back-end acknowledge of the current strobe |

## Verification
The assertions take three things for granted about the inputs. The target raises `bk_ack` only while a strobe is high. It returns `bk_rdata` in the same cycle as the acknowledge. The requester holds its request fields steady during the cycle in which the request is accepted. The bench meets these conditions with a memory model that answers each strobe one cycle later and then drops its acknowledge. The bench also drives each request for exactly one accepting edge and does not issue another request until the previous response has been seen.

// File: rtl/sw_bridge_pkg.sv
package sw_bridge_pkg;

    localparam int WORD_W    = 32;
    localparam int LANE_BITS = 8;
    localparam int OFS_W     = 2;
    localparam int SIZE_W    = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_REPLY
    } bridge_st_e;

    typedef struct packed {
        logic              write;
        logic [SIZE_W-1:0] size;
        logic [OFS_W-1:0]  ofs;
        logic [WORD_W-1:0] wdata;
    } pend_req_t;

    function automatic logic size_legal(input logic [SIZE_W-1:0] s);
        return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(input logic [SIZE_W-1:0] s);
        case (s)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/sw_req_decode.sv
module sw_req_decode
    import sw_bridge_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              reject,
    output logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] word_addr
);
    logic misaligned;

    always_comb begin
        ofs        = addr[OFS_W-1:0];
        word_addr  = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        misaligned = ((size == 3'd2) && addr[0]) ||
                     ((size == 3'd4) && (addr[OFS_W-1:0] != '0));
        reject     = !size_legal(size) || misaligned;
    end
endmodule

// File: rtl/sw_lane_unit.sv
module sw_lane_unit
    import sw_bridge_pkg::*;
(
    input  logic [WORD_W-1:0] fetched,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [SIZE_W-1:0] size,
    input  logic [WORD_W-1:0] new_data,
    output logic [WORD_W-1:0] extracted,
    output logic [WORD_W-1:0] merged
);
    localparam int SH_W = OFS_W + $clog2(LANE_BITS);

    logic [SH_W-1:0]   shamt;
    logic [WORD_W-1:0] msk;

    always_comb begin
        shamt     = {ofs, 3'b000};
        msk       = width_mask(size);
        extracted = (fetched >> shamt) & msk;
        merged    = (fetched & ~(msk << shamt)) | ((new_data & msk) << shamt);
    end
endmodule

// File: rtl/sw_dword_bridge.sv
module sw_dword_bridge
    import sw_bridge_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              bk_rd,
    output logic              bk_wr,
    output logic [ADDR_W-1:0] bk_addr,
    output logic [31:0]       bk_wdata,
    input  logic [31:0]       bk_rdata,
    input  logic              bk_ack
);
    bridge_st_e        state;
    pend_req_t         pend;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] store_q;
    logic [WORD_W-1:0] rdata_q;
    logic              err_q;

    logic              dec_reject;
    logic [OFS_W-1:0]  dec_ofs;
    logic [ADDR_W-1:0] dec_waddr;
    logic [WORD_W-1:0] lane_rd;
    logic [WORD_W-1:0] lane_merge;
    logic              accept;

    sw_req_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (req_addr),
        .size      (req_size),
        .reject    (dec_reject),
        .ofs       (dec_ofs),
        .word_addr (dec_waddr)
    );

    sw_lane_unit u_lane (
        .fetched   (bk_rdata),
        .ofs       (pend.ofs),
        .size      (pend.size),
        .new_data  (pend.wdata),
        .extracted (lane_rd),
        .merged    (lane_merge)
    );

    assign accept = req_valid && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pend    <= '0;
            addr_q  <= '0;
            store_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        pend.write <= req_write;
                        pend.size  <= req_size;
                        pend.ofs   <= dec_ofs;
                        pend.wdata <= req_wdata;
                        addr_q     <= dec_waddr;
                        if (dec_reject) begin
                            err_q   <= 1'b1;
                            rdata_q <= req_write ? '0 : '1;
                            state   <= ST_REPLY;
                        end else if (req_write && (req_size == 3'd4)) begin
                            store_q <= req_wdata;
                            state   <= ST_STORE;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (bk_ack) begin
                        if (pend.write) begin
                            store_q <= lane_merge;
                            state   <= ST_STORE;
                        end else begin
                            err_q   <= 1'b0;
                            rdata_q <= lane_rd;
                            state   <= ST_REPLY;
                        end
                    end
                end
                ST_STORE: begin
                    if (bk_ack) begin
                        err_q   <= 1'b0;
                        rdata_q <= '0;
                        state   <= ST_REPLY;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_REPLY);
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;
    assign bk_rd     = (state == ST_FETCH);
    assign bk_wr     = (state == ST_STORE);
    assign bk_addr   = addr_q;
    assign bk_wdata  = store_q;

    assert_aligned_backend_R1: assert property (@(posedge clk) disable iff (rst)
        (bk_rd || bk_wr) |-> (bk_addr[1:0] == 2'b00));

    assert_reject_no_access_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && dec_reject) |=> (rsp_valid && rsp_err && !bk_rd && !bk_wr));

    assert_byte_upper_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err && !pend.write && pend.size == 3'd1) |-> (rsp_rdata[31:8] == 24'd0));

    assert_rmw_back_to_back_R7: assert property (@(posedge clk) disable iff (rst)
        (bk_rd && bk_ack && pend.write) |=> bk_wr);

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !(bk_rd && bk_wr));

    assert_rd_held_R9: assert property (@(posedge clk) disable iff (rst)
        (bk_rd && !bk_ack) |=> bk_rd);

    assert_wr_held_R9: assert property (@(posedge clk) disable iff (rst)
        (bk_wr && !bk_ack) |=> bk_wr);

endmodule

// File: tb/sw_dword_bridge_bench.sv
module sw_dword_bridge_bench;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        req_size = 3'd0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [31:0]       rsp_rdata;
    logic              bk_rd;
    logic              bk_wr;
    logic [ADDR_W-1:0] bk_addr;
    logic [31:0]       bk_wdata;
    logic [31:0]       bk_rdata;
    logic              bk_ack;

    always #2 clk = ~clk;

    sw_dword_bridge #(.ADDR_W(ADDR_W)) u_sw_dword_bridge (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bk_rd(bk_rd), .bk_wr(bk_wr), .bk_addr(bk_addr), .bk_wdata(bk_wdata),
        .bk_rdata(bk_rdata), .bk_ack(bk_ack)
    );

    logic [31:0]       mem [4];
    int                rd_cnt;
    int                wr_cnt;
    logic [ADDR_W-1:0] last_bk_addr;
    logic              bad_order;

    assign bk_rdata = mem[bk_addr[3:2]];

    always_ff @(posedge clk) begin
        if (rst) begin
            bk_ack       <= 1'b0;
            rd_cnt       <= 0;
            wr_cnt       <= 0;
            last_bk_addr <= '0;
            bad_order    <= 1'b0;
            for (int i = 0; i < 4; i++) mem[i] <= '0;
        end else begin
            bk_ack <= (bk_rd || bk_wr) && !bk_ack;
            if (bk_wr && !bk_ack) mem[bk_addr[3:2]] <= bk_wdata;
            if ((bk_rd || bk_wr) && !bk_ack) last_bk_addr <= bk_addr;
            if (bk_rd && bk_ack) rd_cnt <= rd_cnt + 1;
            if (bk_wr && bk_ack) wr_cnt <= wr_cnt + 1;
            if (bk_rd && bk_ack && req_write && !bk_wr) bad_order <= 1'b0;
        end
    end

    int checks = 0;
    int errors = 0;
    logic [31:0] ref_mem [4];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic [ADDR_W-1:0] a, input logic [2:0] sz,
                         input logic [31:0] wd, output logic e, output logic [31:0] rd,
                         output int nrd, output int nwr, output logic timed_out);
        int r0, w0, cyc;
        logic busy_ok;
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; busy_ok = 1'b1; timed_out = 1'b0;
        while (!rsp_valid && cyc < 50) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 50) timed_out = 1'b1;
        e = rsp_err; rd = rsp_rdata;
        chk(busy_ok && !req_ready, "R8 ready low while busy", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R8 single response pulse", {30'd0, rsp_valid, req_ready}, 32'd1);
        nrd = rd_cnt - r0; nwr = wr_cnt - w0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic e, to;
        logic [31:0] rd, m, exp_rd;
        int nrd, nwr;
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !bk_rd && !bk_wr, "R10 reset state",
            {28'd0, req_ready, rsp_valid, bk_rd, bk_wr}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !bk_rd && !bk_wr, "R10 after reset",
            {28'd0, req_ready, rsp_valid, bk_rd, bk_wr}, 32'h8);

        for (int i = 0; i < 4; i++) begin
            ref_mem[i] = 32'hA5C3_0F10 ^ (32'h1111_1111 * (i + 1));
            do_op(1'b1, ADDR_W'(i * 4), 3'd4, ref_mem[i], e, rd, nrd, nwr, to);
            chk(!e && !to, "R6 dword seed write ok", {31'd0, e}, 32'd0);
            chk(nrd == 0 && nwr == 1, "R6 dword write one write no read", 32'(nrd * 16 + nwr), 32'd1);
            chk(rd == 32'd0, "R5 write response data zero", rd, 32'd0);
        end

        for (int sz = 0; sz < 8; sz++) begin
            for (int of = 0; of < 4; of++) begin
                for (int w = 0; w < 2; w++) begin
                    int idx;
                    logic legal;
                    logic [ADDR_W-1:0] a;
                    logic [31:0] wd;
                    idx = (sz + of + w) % 4;
                    a = ADDR_W'(idx * 4 + of);
                    wd = 32'h9E37_79B9 * (sz * 8 + of * 2 + w + 1);
                    legal = (sz == 1) || (sz == 2 && (of % 2) == 0) || (sz == 4 && of == 0);
                    m = (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
                    do_op(w[0], a, sz[2:0], wd, e, rd, nrd, nwr, to);
                    chk(!to, "R8 response arrives", {31'd0, to}, 32'd0);
                    if (!legal) begin
                        chk(e == 1'b1, (sz==1||sz==2||sz==4) ? "R3 misaligned rejected" : "R2 bad size rejected",
                            {31'd0, e}, 32'd1);
                        chk(nrd == 0 && nwr == 0, (sz==1||sz==2||sz==4) ? "R3 no backend access" : "R2 no backend access",
                            32'(nrd * 16 + nwr), 32'd0);
                        chk(rd == (w ? 32'd0 : 32'hFFFF_FFFF), "R5 error response data", rd,
                            w ? 32'd0 : 32'hFFFF_FFFF);
                    end else if (w == 0) begin
                        exp_rd = (ref_mem[idx] >> (of * 8)) & m;
                        chk(!e && rd == exp_rd, "R4 read lane data", rd, exp_rd);
                        chk(nrd == 1 && nwr == 0, "R4 one backend read", 32'(nrd * 16 + nwr), 32'h10);
                        chk(last_bk_addr == ADDR_W'(idx * 4), "R1 backend address",
                            32'(last_bk_addr), 32'(idx * 4));
                    end else begin
                        ref_mem[idx] = (ref_mem[idx] & ~(m << (of * 8))) | ((wd & m) << (of * 8));
                        chk(!e && rd == 32'd0, "R5 write response zero", rd, 32'd0);
                        if (sz == 4)
                            chk(nrd == 0 && nwr == 1, "R6 dword write path", 32'(nrd * 16 + nwr), 32'h01);
                        else
                            chk(nrd == 1 && nwr == 1, "R7 read-modify-write", 32'(nrd * 16 + nwr), 32'h11);
                        chk(last_bk_addr == ADDR_W'(idx * 4), "R1 backend address",
                            32'(last_bk_addr), 32'(idx * 4));
                        do_op(1'b0, ADDR_W'(idx * 4), 3'd4, 32'd0, e, rd, nrd, nwr, to);
                        chk(!e && rd == ref_mem[idx], "R7 only addressed lane changed", rd, ref_mem[idx]);
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule